// File: doc/BRIEF.md
# Grouped Clock Output Divider Controller

This block produces fifteen gated clock lanes, arranged in four groups of eight, four, two and one lanes, plus a passthrough of a reference clock. It runs on a timing clock `clk_i` that is twice the full output rate. Each lane runs at the full rate, with a period of two `clk_i` cycles, or at half that rate, with a period of four cycles. Every lane also carries a tri-state enable next to its clock value, so pad drivers can be modelled without bidirectional ports.

The half-rate choice for a lane comes from one of two sources, picked by a mode input:
- a strap pin shared by the lane's group, or
- a per-lane configuration bit.

Each lane has an enable bit. A global output-enable pin overrides all lane enables and the reference enable. An active-low stop input parks all clock lanes low without tri-stating them.

The strap, global-enable and stop pins are asynchronous and are resynchronised. Configuration vectors are assumed synchronous to `clk_i`. All lanes share one phase counter, so lanes at the same rate stay aligned. Every configuration change is committed at the counter's wrap, where all lanes start a low phase.

Top module: `clkgrp_ctrl`

## Requirements
- R1: While `rst_ni` is low, every `clk_o` bit and every `clk_oe_o` bit is 0, and `ref_oe_o` is 0.
- R2: A running lane at full rate toggles on every `clk_i` cycle (period of 2 cycles).
- R3: A running lane at half rate repeats 2 cycles high then 2 cycles low, and every high pulse lasts 2 cycles.
- R4: With `freq_mode_i`=0, lane i is half rate exactly when `grp_half_i[g]`=1. Here g is 0 for lanes 0-7, 1 for lanes 8-11, 2 for lanes 12-13 and 3 for lane 14. In this mode `lane_half_i` has no effect.
- R5: With `freq_mode_i`=1, lane i is half rate exactly when `lane_half_i[i]`=1, and `grp_half_i` has no effect.
- R6: The phase counter advances by one every cycle. All half-rate lanes carry identical values in every cycle.
- R7: With `lane_en_i[i]`=0, `clk_oe_o[i]` is 0 and `clk_o[i]` is held at 0.
- R8: With `glob_oe_i`=0, every `clk_oe_o` bit and `ref_oe_o` are 0, whatever the lane enables are.
- R9: With `stop_ni`=0, every `clk_o` bit settles at 0 while `clk_oe_o` keeps its enable value. `ref_o` is unaffected. When `stop_ni` returns to 1, the lanes resume their programmed rate.
- R10: `ref_o` equals `ref_i` at all times, and `ref_oe_o` = `ref_en_i` AND the synchronised `glob_oe_i`.
- R11: A lane's `clk_oe_o` only changes in a cycle where its `clk_o` is 0. A rate change never shortens a high pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock, twice the full output rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference clock to pass through |
| grp_half_i | input | 4 | Per-group strap pins, 1 selects half rate (asynchronous) |
| freq_mode_i | input | 1 | 0: straps select the rate, 1: per-lane bits select it |
| lane_half_i | input | 15 | Per-lane half-rate bits |
| lane_en_i | input | 15 | Per-lane enables, 1 drives, 0 tri-states |
| ref_en_i | input | 1 | Reference output enable |
| glob_oe_i | input | 1 | Global output enable (asynchronous) |
| stop_ni | input | 1 | Active-low clock stop (asynchronous) |
| clk_o | output | 15 | Lane clock values |
| clk_oe_o | output | 15 | Lane tri-state enables, 1 drives |
| ref_o | output | 1 | Reference clock out |
| ref_oe_o | output | 1 | Reference tri-state enable |

## Verification
The assertions assume the following about the inputs:
- `freq_mode_i`, `lane_half_i` and `lane_en_i` change only in step with `clk_i`.
- `grp_half_i`, `glob_oe_i` and `stop_ni` hold their values long enough to cross the synchroniser.

The stimulus meets this by driving every input on the falling edge of `clk_i`. After each change, the bench waits sixteen cycles, which covers synchronisation and the next commit, before it classifies the lane waveforms. The check of enable edges against low phases runs while enables and rates are toggled in mid-stream.

// File: rtl/clkgrp_pkg.sv
package clkgrp_pkg;
  localparam int unsigned N_GRP = 4;
  localparam int unsigned GRP_SZ [N_GRP] = '{8, 4, 2, 1};
  localparam int unsigned PH_W = 2;

  function automatic int unsigned lane_total();
    int unsigned s;
    s = 0;
    for (int unsigned g = 0; g < N_GRP; g++) s += GRP_SZ[g];
    return s;
  endfunction

  localparam int unsigned N_LANE = lane_total();

  function automatic int unsigned grp_of(int unsigned lane);
    int unsigned base;
    int unsigned res;
    base = 0;
    res  = N_GRP - 1;
    for (int g = N_GRP - 1; g >= 0; g--) begin
      base = 0;
      for (int h = 0; h < g; h++) base += GRP_SZ[h];
      if (lane >= base && res == N_GRP - 1 && g != N_GRP - 1) res = int'(g);
      if (lane >= base) break;
    end
    return res;
  endfunction

  typedef struct packed {
    logic half;
    logic en;
    logic run;
  } lane_cfg_t;
endpackage

// File: rtl/clkgrp_sync.sv
module clkgrp_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clkgrp_phase.sv
module clkgrp_phase import clkgrp_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] ph_o,
  output logic            commit_o
);
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_q + 1'b1;
  end

  assign ph_o     = ph_q;
  // wrap point: every lane is about to enter a low phase
  assign commit_o = (ph_q == '0);

  a_r6_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ph_q == PH_W'($past(ph_q) + 1'b1));
endmodule

// File: rtl/clkgrp_lane.sv
module clkgrp_lane import clkgrp_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PH_W-1:0] ph_i,
  input  logic            commit_i,
  input  lane_cfg_t       req_i,
  output logic            clk_o,
  output logic            oe_o
);
  lane_cfg_t act_q;
  logic      q;
  logic      wave;

  assign wave = act_q.half ? ph_i[1] : ph_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      q     <= 1'b0;
    end else begin
      if (commit_i) act_q <= req_i;
      q <= act_q.en & act_q.run & wave;
    end
  end

  assign clk_o = q;
  assign oe_o  = act_q.en;

  a_r2_full_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_o && !act_q.half) |=> !clk_o);
  a_r3_half_double: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(clk_o) && act_q.half) |=> clk_o);
  a_r11_oe_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_o) |-> !clk_o);
  a_r9_stop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !req_i.run) |=> !clk_o ##1 !clk_o);
endmodule

// File: rtl/clkgrp_ctrl.sv
module clkgrp_ctrl import clkgrp_pkg::*; #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_i,
  input  logic [N_GRP-1:0]  grp_half_i,
  input  logic              freq_mode_i,
  input  logic [N_LANE-1:0] lane_half_i,
  input  logic [N_LANE-1:0] lane_en_i,
  input  logic              ref_en_i,
  input  logic              glob_oe_i,
  input  logic              stop_ni,
  output logic [N_LANE-1:0] clk_o,
  output logic [N_LANE-1:0] clk_oe_o,
  output logic              ref_o,
  output logic              ref_oe_o
);
  localparam int unsigned PIN_W = N_GRP + 2;

  logic [PIN_W-1:0] pin_q;
  logic [N_GRP-1:0] grp_q;
  logic             glob_q;
  logic             run_q;
  logic [PH_W-1:0]  ph;
  logic             commit;

  clkgrp_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({stop_ni, glob_oe_i, grp_half_i}),
    .q_o    (pin_q)
  );

  assign grp_q  = pin_q[N_GRP-1:0];
  assign glob_q = pin_q[N_GRP];
  assign run_q  = pin_q[N_GRP+1];

  clkgrp_phase u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ph_o     (ph),
    .commit_o (commit)
  );

  for (genvar i = 0; i < N_LANE; i++) begin : g_lane
    localparam int unsigned GI = grp_of(i);
    lane_cfg_t req;

    assign req.half = freq_mode_i ? lane_half_i[i] : grp_q[GI];
    assign req.en   = lane_en_i[i] & glob_q;
    assign req.run  = run_q;

    clkgrp_lane u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ph_i     (ph),
      .commit_i (commit),
      .req_i    (req),
      .clk_o    (clk_o[i]),
      .oe_o     (clk_oe_o[i])
    );
  end

  assign ref_o    = ref_i;
  assign ref_oe_o = ref_en_i & glob_q;

  a_r8_global_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !glob_q) |=> (clk_oe_o == '0));
endmodule

// File: tb/sim_clkgrp_ctrl.sv
`timescale 1ns/1ps
module sim_clkgrp_ctrl;
  import clkgrp_pkg::*;
  localparam int NL = 15;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          ref_i = 1'b0;
  logic [3:0]    grp_half = '0;
  logic          mode = 1'b0;
  logic [NL-1:0] lane_half = '0;
  logic [NL-1:0] lane_en = '1;
  logic          ref_en = 1'b1;
  logic          glob = 1'b1;
  logic          stop_n = 1'b1;
  logic [NL-1:0] clk_o, clk_oe;
  logic          ref_o, ref_oe;

  clkgrp_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_i), .grp_half_i(grp_half),
    .freq_mode_i(mode), .lane_half_i(lane_half), .lane_en_i(lane_en),
    .ref_en_i(ref_en), .glob_oe_i(glob), .stop_ni(stop_n),
    .clk_o(clk_o), .clk_oe_o(clk_oe), .ref_o(ref_o), .ref_oe_o(ref_oe)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [NL-1:0] smp [8];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int grp(int l);
    return (l < 8) ? 0 : (l < 12) ? 1 : (l < 14) ? 2 : 3;
  endfunction

  task automatic settle();
    repeat (16) @(posedge clk);
    @(negedge clk);
  endtask

  // class codes: 0 low, 1 full, 2 half, 3 other
  function automatic int classify(int l);
    bit all0, full, half;
    all0 = 1; full = 1; half = 1;
    for (int k = 0; k < 8; k++) if (smp[k][l]) all0 = 0;
    for (int k = 0; k < 7; k++) if (smp[k][l] == smp[k+1][l]) full = 0;
    for (int k = 0; k < 6; k++) if (smp[k][l] == smp[k+2][l]) half = 0;
    if (all0) return 0;
    if (full) return 1;
    if (half) return 2;
    return 3;
  endfunction

  task automatic expect_all(input string req);
    int first_half;
    for (int k = 0; k < 8; k++) begin
      smp[k] = clk_o;
      @(negedge clk);
    end
    first_half = -1;
    for (int l = 0; l < NL; l++) begin
      bit on, hf;
      int ec;
      on = lane_en[l] & glob;
      hf = mode ? lane_half[l] : grp_half[grp(l)];
      ec = (!on || !stop_n) ? 0 : (hf ? 2 : 1);
      chk(classify(l) == ec, req, classify(l), ec);
      chk(clk_oe[l] == on, req, clk_oe[l], on);
      if (ec == 2) begin
        if (first_half < 0) first_half = l;
        else for (int k = 0; k < 8; k++)
          chk(smp[k][l] == smp[k][first_half], "R6 half lanes aligned", smp[k][l], smp[k][first_half]);
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(clk_o == '0, "R1 reset clk_o", clk_o, 0);
    chk(clk_oe == '0, "R1 reset clk_oe_o", clk_oe, 0);
    chk(ref_oe == 1'b0, "R1 reset ref_oe_o", ref_oe, 0);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic t_strap();
    mode = 1'b0;
    lane_half = 15'h5555;
    grp_half = 4'b0000; settle(); expect_all("R2 R4 straps all full");
    grp_half = 4'b1111; settle(); expect_all("R3 R4 straps all half");
    grp_half = 4'b0101; settle(); expect_all("R4 strap groups 0 and 2 half");
    grp_half = 4'b1010; settle(); expect_all("R4 strap groups 1 and 3 half");
  endtask

  task automatic t_reg();
    mode = 1'b1;
    grp_half = 4'b1111;
    lane_half = 15'h0000; settle(); expect_all("R5 reg bits all full, straps ignored");
    lane_half = 15'h2A5C; settle(); expect_all("R5 R6 reg bits mixed");
    grp_half = 4'b0000;   settle(); expect_all("R5 strap change ignored");
    lane_half = 15'h7FFF; settle(); expect_all("R3 R5 reg bits all half");
  endtask

  task automatic t_enable();
    mode = 1'b1;
    lane_half = 15'h00F0;
    lane_en = 15'h6B3D; settle(); expect_all("R7 lane enables mixed");
    lane_en = 15'h0000; settle(); expect_all("R7 all lanes disabled");
    lane_en = '1;       settle(); expect_all("R7 enables restored");
  endtask

  task automatic t_global();
    glob = 1'b0; settle(); expect_all("R8 global enable off");
    chk(clk_oe == '0, "R8 clk_oe_o", clk_oe, 0);
    chk(ref_oe == 1'b0, "R8 ref_oe_o", ref_oe, 0);
    glob = 1'b1; settle(); expect_all("R8 global enable on");
  endtask

  task automatic t_stop();
    lane_half = 15'h0F0F;
    stop_n = 1'b0; settle(); expect_all("R9 stopped lanes low, oe kept");
    chk(clk_oe == lane_en, "R9 oe during stop", clk_oe, lane_en);
    stop_n = 1'b1; settle(); expect_all("R9 resume after stop");
  endtask

  task automatic t_ref();
    stop_n = 1'b0;
    settle();
    for (int k = 0; k < 6; k++) begin
      ref_i = ~ref_i;
      #1;
      chk(ref_o == ref_i, "R10 R9 ref passthrough while stopped", ref_o, ref_i);
      @(negedge clk);
    end
    ref_en = 1'b0; #1;
    chk(ref_oe == 1'b0, "R10 ref_oe_o off", ref_oe, 0);
    ref_en = 1'b1; #1;
    chk(ref_oe == 1'b1, "R10 ref_oe_o on", ref_oe, 1);
    stop_n = 1'b1;
    settle();
  endtask

  task automatic t_switch();
    logic [NL-1:0] prev_oe;
    int viol;
    viol = 0;
    prev_oe = clk_oe;
    for (int c = 0; c < 60; c++) begin
      if (c % 5 == 0) lane_en = lane_en ^ 15'h1249;
      if (c % 7 == 0) lane_half = ~lane_half;
      @(negedge clk);
      for (int l = 0; l < NL; l++)
        if (clk_oe[l] != prev_oe[l] && clk_o[l]) viol++;
      prev_oe = clk_oe;
    end
    chk(viol == 0, "R11 oe edges only in low phase", viol, 0);
    lane_en = '1;
    settle();
    expect_all("R11 settled after churn");
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_strap();
    t_reg();
    t_enable();
    t_global();
    t_stop();
    t_ref();
    t_switch();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule